// File: doc/BRIEF.md
# Bank Address Capture and Access Checker

This block sits between a CPU with a 16-bit address bus and a banked SRAM array. The CPU places the upper address byte on its data bus during the low phase of its bus clock. The block latches that byte when the cycle is marked valid by either of the two valid-address strobes. It keeps the byte stable through the high phase and decodes it into one chip select per installed RAM bank. It also records what kind of cycle is running: internal, operand fetch, data access or opcode fetch.

When protection is enabled and the CPU is not in kernel mode, the latched bank is compared with the bank that belongs to the running process. A valid access to any other bank is blocked, and it raises a sticky abort request that stays set until the mode controller clears it. Bank 0 is exempt from this check, because the CPU sends its zero-page, stack and vector accesses there whatever program is running. With protection off, the bank passes straight through and no abort is ever raised.

All state is sampled on the system clock `clk`. `phi2` is the CPU bus phase, seen as a level input.

Top module: `bank_guard`

## Requirements
- R1: After reset, `bank_q` is 0, `cyc_kind` is 0 (internal), every chip select is low and `abort` is low.
- R2: At a `clk` edge where `phi2` is low and `vda` or `vpa` is high, `d_bus` is stored in `bank_q`. `bank_q` holds that value through the following `phi2` high phase even if `d_bus` changes. `bank_sel` is the low log2(NUM_BANKS) bits of `bank_q`.
- R3: A cycle with `vda`=0 and `vpa`=0 is internal. It leaves `bank_q` at its previous value, asserts no chip select and raises no abort.
- R4: At every `clk` edge with `phi2` low, `cyc_kind` takes the value {vda,vpa}: 00 internal, 01 operand fetch, 10 data access, 11 opcode fetch.
- R5: Chip selects are asserted only while `phi2` is high during a valid cycle. At most one is high, and it is `cs[bank_q]`.
- R6: A latched bank of NUM_BANKS (16) or above asserts no chip select.
- R7: A valid cycle with `prot_en`=1, `kernel`=0, a nonzero `bank_q` and `bank_q` different from `cur_bank` is a violation. Its chip select is suppressed, and `abort` rises at the `clk` edge inside that `phi2` high phase.
- R8: A bank 0 access in user mode raises no abort and asserts `cs[0]`.
- R9: With `kernel`=1, accesses to any bank raise no abort and assert their chip select.
- R10: With `prot_en`=0, no abort is raised and chip selects follow `bank_q` unchanged.
- R11: `abort` stays high until a `clk` edge with `viol_clr`=1. If a new violation occurs at that same edge, the violation wins and `abort` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | CPU bus phase level (low: bank byte on bus) |
| vda | input | 1 | Valid data address strobe |
| vpa | input | 1 | Valid program address strobe |
| d_bus | input | 8 | CPU data bus carrying the bank byte |
| cur_bank | input | 8 | Bank owned by the running process |
| prot_en | input | 1 | Protection enable (0 = real mode) |
| kernel | input | 1 | Kernel mode, exempt from checking |
| viol_clr | input | 1 | Clears the sticky abort |
| bank_q | output | 8 | Latched bank byte |
| bank_sel | output | 4 | Bank select bits to the SRAM array |
| cyc_kind | output | 2 | Latched cycle kind {vda,vpa} |
| cs | output | 16 | One-hot RAM bank chip selects |
| abort | output | 1 | Sticky abort request |

## Verification
The hardest situation to reach from the ports is a violation and a clear arriving at the same clock edge. The clear must land exactly in the `phi2` high phase of a mismatching user-mode cycle. A directed step asserts `viol_clr` only in that phase. Randomly chosen banks are weighted toward the process bank, bank 0 and out-of-range values, so that exemptions, out-of-range banks and mismatches all occur many times in every mode. The bank also has to hold across an internal cycle, so random data is driven on the bus during each high phase and internal cycles are mixed in.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;
   // Cycle kind, encoded as {vda, vpa}
   typedef enum logic [1:0] {
      CYC_INTERNAL = 2'b00,
      CYC_OPERAND  = 2'b01,
      CYC_DATA     = 2'b10,
      CYC_OPCODE   = 2'b11
   } cyc_kind_e;
endpackage

// File: rtl/bank_capture.sv
module bank_capture
   import bank_guard_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              vda,
   input  logic              vpa,
   input  logic [BANK_W-1:0] d_bus,
   output logic [BANK_W-1:0] bank_q,
   output cyc_kind_e         kind_q
);
   logic addr_ok;
   assign addr_ok = vda | vpa;

   // Low phase: the kind follows the strobes; the bank is taken only on valid cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         kind_q <= CYC_INTERNAL;
      end else if (!phi2) begin
         kind_q <= cyc_kind_e'({vda, vpa});
         if (addr_ok) bank_q <= d_bus;
      end
   end
endmodule

// File: rtl/bank_police.sv
module bank_police
   import bank_guard_pkg::*;
#(
   parameter int BANK_W      = 8,
   parameter bit EXEMPT_ZERO = 1'b1
) (
   input  logic [BANK_W-1:0] bank_q,
   input  cyc_kind_e         kind_q,
   input  logic [BANK_W-1:0] cur_bank,
   input  logic              prot_en,
   input  logic              kernel,
   output logic              mismatch
);
   logic exempt;

   generate
      if (EXEMPT_ZERO) begin : g_zero_free
         assign exempt = (bank_q == '0);
      end else begin : g_zero_checked
         assign exempt = 1'b0;
      end
   endgenerate

   assign mismatch = (kind_q != CYC_INTERNAL) && prot_en && !kernel
                     && (bank_q != cur_bank) && !exempt;
endmodule

// File: rtl/bank_chipsel.sv
module bank_chipsel
   import bank_guard_pkg::*;
#(
   parameter int BANK_W    = 8,
   parameter int NUM_BANKS = 16
) (
   input  logic                 phi2,
   input  logic [BANK_W-1:0]    bank_q,
   input  cyc_kind_e            kind_q,
   input  logic                 block,
   output logic [NUM_BANKS-1:0] cs
);
   logic enable;
   assign enable = phi2 && (kind_q != CYC_INTERNAL) && !block;

   // One comparator per installed bank; banks beyond the array match none
   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
         assign cs[b] = enable && (bank_q == BANK_W'(b));
      end
   endgenerate
endmodule

// File: rtl/bank_guard.sv
module bank_guard
   import bank_guard_pkg::*;
#(
   parameter int BANK_W      = 8,
   parameter int NUM_BANKS   = 16,
   parameter bit EXEMPT_ZERO = 1'b1,
   localparam int SEL_W      = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 phi2,
   input  logic                 vda,
   input  logic                 vpa,
   input  logic [BANK_W-1:0]    d_bus,
   input  logic [BANK_W-1:0]    cur_bank,
   input  logic                 prot_en,
   input  logic                 kernel,
   input  logic                 viol_clr,
   output logic [BANK_W-1:0]    bank_q,
   output logic [SEL_W-1:0]     bank_sel,
   output logic [1:0]           cyc_kind,
   output logic [NUM_BANKS-1:0] cs,
   output logic                 abort
);
   generate
      if (NUM_BANKS < 2 || NUM_BANKS > (1 << BANK_W)) begin : g_bad_banks
         $error("bank_guard: NUM_BANKS must lie in 2 .. 2**BANK_W");
      end
   endgenerate

   cyc_kind_e kind_q;
   logic      mismatch;
   logic      viol_q;

   bank_capture #(.BANK_W(BANK_W)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .phi2   (phi2),
      .vda    (vda),
      .vpa    (vpa),
      .d_bus  (d_bus),
      .bank_q (bank_q),
      .kind_q (kind_q)
   );

   bank_police #(.BANK_W(BANK_W), .EXEMPT_ZERO(EXEMPT_ZERO)) u_police (
      .bank_q   (bank_q),
      .kind_q   (kind_q),
      .cur_bank (cur_bank),
      .prot_en  (prot_en),
      .kernel   (kernel),
      .mismatch (mismatch)
   );

   bank_chipsel #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_chipsel (
      .phi2   (phi2),
      .bank_q (bank_q),
      .kind_q (kind_q),
      .block  (mismatch),
      .cs     (cs)
   );

   // Sticky flag: set in the high phase of an offending cycle, set beats clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 viol_q <= 1'b0;
      else if (phi2 && mismatch)  viol_q <= 1'b1;
      else if (viol_clr)          viol_q <= 1'b0;
   end

   assign abort    = viol_q;
   assign cyc_kind = kind_q;
   assign bank_sel = bank_q[SEL_W-1:0];
endmodule

// File: rtl/bank_guard_chk.sv
module bank_guard_chk #(
   parameter int BANK_W      = 8,
   parameter int NUM_BANKS   = 16,
   parameter bit EXEMPT_ZERO = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 phi2,
   input logic                 vda,
   input logic                 vpa,
   input logic [BANK_W-1:0]    cur_bank,
   input logic                 prot_en,
   input logic                 kernel,
   input logic                 viol_clr,
   input logic [BANK_W-1:0]    bank_q,
   input logic [1:0]           cyc_kind,
   input logic [NUM_BANKS-1:0] cs,
   input logic                 abort
);
   a_r2_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (phi2 || !(vda || vpa)) |=> $stable(bank_q));

   a_r3_no_cs_internal: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_kind == 2'b00) |-> (cs == '0));

   a_r5_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs));

   a_r5_no_cs_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !phi2 |-> (cs == '0));

   a_r6_no_cs_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, bank_q} >= (BANK_W+1)'(NUM_BANKS)) |-> (cs == '0));

   a_r7_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (phi2 && cyc_kind != 2'b00 && prot_en && !kernel && bank_q != cur_bank
       && (bank_q != '0 || !EXEMPT_ZERO)) |=> abort);

   a_r9_kernel_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (kernel && !abort) |=> !abort);

   a_r10_real_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!prot_en && !abort) |=> !abort);

   a_r11_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !viol_clr) |=> abort);
endmodule

bind bank_guard bank_guard_chk #(
   .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .EXEMPT_ZERO(EXEMPT_ZERO)
) u_chk (
   .clk(clk), .rst_n(rst_n), .phi2(phi2), .vda(vda), .vpa(vpa),
   .cur_bank(cur_bank), .prot_en(prot_en), .kernel(kernel),
   .viol_clr(viol_clr), .bank_q(bank_q), .cyc_kind(cyc_kind),
   .cs(cs), .abort(abort)
);

// File: tb/bank_guard_tb.sv
module bank_guard_tb;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          phi2 = 1'b0, vda = 1'b0, vpa = 1'b0;
   logic [7:0]    d_bus = '0, cur_bank = 8'd1;
   logic          prot_en = 1'b0, kernel = 1'b0, viol_clr = 1'b0;
   logic [7:0]    bank_q;
   logic [3:0]    bank_sel;
   logic [1:0]    cyc_kind;
   logic [NB-1:0] cs;
   logic          abort;

   int n_chk = 0, n_bad = 0;
   logic [7:0] m_bank = '0;
   logic [1:0] m_kind = '0;
   logic       m_abort = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   bank_guard u_dut (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .vda(vda), .vpa(vpa),
      .d_bus(d_bus), .cur_bank(cur_bank), .prot_en(prot_en), .kernel(kernel),
      .viol_clr(viol_clr), .bank_q(bank_q), .bank_sel(bank_sel),
      .cyc_kind(cyc_kind), .cs(cs), .abort(abort)
   );

   function automatic logic f_mism(logic [7:0] b, logic [1:0] k);
      return (k != 2'b00) && prot_en && !kernel && (b != cur_bank) && (b != 8'd0);
   endfunction

   function automatic logic [NB-1:0] f_cs(logic [7:0] b, logic [1:0] k);
      if (k == 2'b00 || f_mism(b, k) || b >= NB) return '0;
      return NB'(1) << b;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One CPU bus cycle: low phase with the bank byte, high phase with junk on the bus
   task automatic bus(logic a_vda, logic a_vpa, logic [7:0] byte_in,
                      logic clr_high, string req);
      logic m;
      @(negedge clk);
      phi2 = 1'b0; vda = a_vda; vpa = a_vpa; d_bus = byte_in; viol_clr = 1'b0;
      @(negedge clk);
      m_kind = {a_vda, a_vpa};
      if (a_vda || a_vpa) m_bank = byte_in;
      phi2 = 1'b1; vda = 1'b0; vpa = 1'b0; d_bus = 8'($urandom); viol_clr = clr_high;
      #1;
      check({req, " R2 bank"}, 32'(bank_q), 32'(m_bank));
      check({req, " R2 sel"}, 32'(bank_sel), 32'(m_bank[3:0]));
      check({req, " R4 kind"}, 32'(cyc_kind), 32'(m_kind));
      check({req, " R5 cs"}, 32'(cs), 32'(f_cs(m_bank, m_kind)));
      m = f_mism(m_bank, m_kind);
      m_abort = m ? 1'b1 : (clr_high ? 1'b0 : m_abort);
      @(posedge clk);
      #1;
      viol_clr = 1'b0;
      check({req, " R7/R11 abort"}, 32'(abort), 32'(m_abort));
   endtask

   task automatic clear_abort();
      @(negedge clk);
      phi2 = 1'b0; vda = 1'b0; vpa = 1'b0; viol_clr = 1'b1;
      @(posedge clk);
      #1;
      viol_clr = 1'b0;
      m_kind = 2'b00;
      m_abort = 1'b0;
      check("R11 clear", 32'(abort), 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd2024));
      #20;
      phi2 = 1'b1;
      #1;
      check("R1 bank", 32'(bank_q), 32'd0);
      check("R1 kind", 32'(cyc_kind), 32'd0);
      check("R1 cs", 32'(cs), 32'd0);
      check("R1 abort", 32'(abort), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: real mode passes any bank through, all cycle kinds (R4)
      prot_en = 1'b0; cur_bank = 8'd3;
      bus(1'b1, 1'b1, 8'd7, 1'b0, "R10 opcode");
      bus(1'b0, 1'b1, 8'd9, 1'b0, "R10 operand");
      bus(1'b1, 1'b0, 8'd12, 1'b0, "R10 data");
      bus(1'b1, 1'b0, 8'd40, 1'b0, "R6 real");
      // R3: internal cycle holds bank, no select
      bus(1'b0, 1'b0, 8'd5, 1'b0, "R3 internal");
      check("R3 bank kept", 32'(bank_q), 32'd40);

      // User mode
      prot_en = 1'b1; kernel = 1'b0; cur_bank = 8'd3;
      bus(1'b1, 1'b1, 8'd3, 1'b0, "R5 match");
      bus(1'b1, 1'b0, 8'd0, 1'b0, "R8 zero");
      bus(1'b0, 1'b0, 8'd9, 1'b0, "R3 user internal");
      bus(1'b1, 1'b0, 8'd6, 1'b0, "R7 mismatch");
      check("R7 abort set", 32'(abort), 32'd1);
      bus(1'b1, 1'b1, 8'd3, 1'b0, "R11 held");
      clear_abort();
      // R11: violation and clear at the same edge, violation wins
      bus(1'b1, 1'b0, 8'd8, 1'b1, "R11 set wins");
      check("R11 set wins", 32'(abort), 32'd1);
      clear_abort();
      // R9: kernel mode
      kernel = 1'b1;
      bus(1'b1, 1'b0, 8'd11, 1'b0, "R9 kernel");
      bus(1'b1, 1'b0, 8'd200, 1'b0, "R6 kernel");
      check("R9 no abort", 32'(abort), 32'd0);

      // Constrained random
      for (int i = 0; i < 600; i++) begin
         logic [7:0] b;
         int sel;
         prot_en = ($urandom_range(3) != 0);
         kernel  = ($urandom_range(3) == 0);
         cur_bank = 8'($urandom_range(15, 1));
         sel = $urandom_range(3);
         case (sel)
            0: b = cur_bank;
            1: b = 8'd0;
            2: b = 8'($urandom_range(15));
            default: b = 8'($urandom);
         endcase
         bus(1'($urandom), 1'($urandom), b, ($urandom_range(7) == 0), "rand");
         if ($urandom_range(5) == 0) clear_abort();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule